// File: doc/BRIEF.md
# Floating-Point Control and Status Register Pair

This block holds the two user-visible configuration words of a floating-point unit. The control word selects the rounding direction, and the block presents that choice to the arithmetic datapath as a registered 2-bit code. The status word keeps five sticky exception flags. The datapath raises these flags one cycle at a time through a flag input, and software can also load them directly.

Software reaches both words through a single 32-bit write port and a single 32-bit read port. The register is chosen by a select bit, where 0 means control and 1 means status. Writes are masked, so that bits with no defined meaning always read back as zero. When a write carries a nonzero value in the upper must-be-zero field, the block emits a one-cycle diagnostic pulse. A build parameter selects a legacy compatibility layout for the control word, which keeps its upper field and reports no error for it.

Top module: `fpcsr_top`

## Requirements
- R1: `round_mode` is a register output equal to control bits [1:0], with 0 meaning nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity. It takes the new value in the cycle after a control write.
- R2: In the default layout, a control write (wr_sel=0) stores only bits [6:0]. Bits [31:7] of the control word read back as zero.
- R3: A status write (wr_sel=1) stores only bits [11:7] as flags: inexact=7, underflow=8, overflow=9, divide-by-zero=10, invalid=11. Every other bit of the write is dropped.
- R4: A read with rd_sel=1 returns the five current flags at bits [11:7] and zero elsewhere. A read with rd_sel=0 returns the control word. The read path is combinational from the stored state.
- R5: A write with any of bits [31:12] set drives `rsvd_err` high for exactly the cycle after that write. The masked write still takes effect. `rsvd_err` is low in every other cycle.
- R6: With COMPAT_CTRL=1, a control write stores the bits of mask 0xFFFFF07F and raises no `rsvd_err`. Status writes behave as in R3 and R5.
- R7: Each bit of `dp_flags` (bit 0 inexact up to bit 4 invalid) is ORed into the stored flags at the clock edge. A flag stays set until software writes the status word.
- R8: When a status write and `dp_flags` fall in the same cycle, the written flags are stored and that cycle's `dp_flags` are discarded.
- R9: Reset (rst_n low) clears both words. After reset, `round_mode` is 0, the flags are zero and `rsvd_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | 32 | Read value |
| dp_flags | input | 5 | Flags raised by the datapath this cycle |
| round_mode | output | 2 | Registered rounding code |
| rsvd_err | output | 1 | One-cycle must-be-zero violation pulse |

## Verification
The hardest case to reach is a status write that lands in the same cycle as nonzero datapath flags. In that cycle, flags that are set in the flag input but clear in the written value must come out clear. The bench drives random write strobes, random selects and sparse random flag vectors at the same time, so these collisions happen often. It also forces one directed collision. Back-to-back writes with reserved bits set check that the error pulse follows each write individually and does not stretch. A second instance built in the compatibility layout receives the same stimulus.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

   typedef enum logic [1:0] {
      RND_NEAREST_EVEN = 2'd0,
      RND_TO_ZERO      = 2'd1,
      RND_POS_INF      = 2'd2,
      RND_NEG_INF      = 2'd3
   } rnd_mode_e;

   typedef enum logic {
      CSR_CTRL = 1'b0,
      CSR_STAT = 1'b1
   } csr_sel_e;

   // Flag order inside the status field, LSB first.
   localparam int unsigned FLG_INEXACT   = 0;
   localparam int unsigned FLG_UNDERFLOW = 1;
   localparam int unsigned FLG_OVERFLOW  = 2;
   localparam int unsigned FLG_DIVZERO   = 3;
   localparam int unsigned FLG_INVALID   = 4;

endpackage

// File: rtl/fpcsr_ctrl_reg.sv
module fpcsr_ctrl_reg
   import fpcsr_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned KEEP_LO_W   = 7,
   parameter int unsigned RSVD_LSB    = 12,
   parameter bit          COMPAT_CTRL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctrl_q,
   output rnd_mode_e         round_mode
);
   localparam logic [DATA_W-1:0] LO_MASK = {DATA_W{1'b1}} >> (DATA_W - KEEP_LO_W);
   localparam logic [DATA_W-1:0] HI_MASK = {DATA_W{1'b1}} << RSVD_LSB;

   logic [DATA_W-1:0] keep_mask;

   generate
      if (COMPAT_CTRL) begin : g_compat
         assign keep_mask = LO_MASK | HI_MASK;
      end else begin : g_strict
         assign keep_mask = LO_MASK;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (we) begin
         ctrl_q <= wdata & keep_mask;
      end
   end

   // Decode the rounding field into the enum used by the datapath.
   always_comb begin
      unique case (ctrl_q[1:0])
         2'd0:    round_mode = RND_NEAREST_EVEN;
         2'd1:    round_mode = RND_TO_ZERO;
         2'd2:    round_mode = RND_POS_INF;
         default: round_mode = RND_NEG_INF;
      endcase
   end
endmodule

// File: rtl/fpcsr_flag_reg.sv
module fpcsr_flag_reg #(
   parameter int unsigned NFLAGS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [NFLAGS-1:0] sw_flags,
   input  logic [NFLAGS-1:0] hw_flags,
   output logic [NFLAGS-1:0] flags_q
);
   logic [NFLAGS-1:0] flags_d;

   genvar gi;
   generate
      for (gi = 0; gi < NFLAGS; gi++) begin : g_bit
         // Software load wins; otherwise accumulate stickily.
         assign flags_d[gi] = sw_we ? sw_flags[gi] : (flags_q[gi] | hw_flags[gi]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_d;
   end
endmodule

// File: rtl/fpcsr_rsvd_chk.sv
module fpcsr_rsvd_chk
   import fpcsr_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RSVD_LSB    = 12,
   parameter bit          COMPAT_CTRL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  csr_sel_e          wr_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic              err_q
);
   localparam int unsigned RSVD_W = DATA_W - RSVD_LSB;

   logic rsvd_set;
   logic target_checked;

   assign rsvd_set = |wdata[DATA_W-1 -: RSVD_W];

   generate
      if (COMPAT_CTRL) begin : g_compat
         assign target_checked = (wr_sel == CSR_STAT);
      end else begin : g_strict
         assign target_checked = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= wr_en & target_checked & rsvd_set;
   end
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
   import fpcsr_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NFLAGS      = 5,
   parameter int unsigned FLAG_LSB    = 7,
   parameter int unsigned KEEP_LO_W   = 7,
   parameter int unsigned RSVD_LSB    = 12,
   parameter bit          COMPAT_CTRL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NFLAGS-1:0] dp_flags,
   output logic [1:0]        round_mode,
   output logic              rsvd_err
);
   localparam int unsigned FLAG_MSB = FLAG_LSB + NFLAGS - 1;

   generate
      if (FLAG_MSB >= RSVD_LSB) begin : g_bad_flag_pos
         $error("flag field overlaps reserved field");
      end
      if (KEEP_LO_W < 2 || KEEP_LO_W > FLAG_LSB) begin : g_bad_keep
         $error("control low field must hold the rounding bits and stay below flags");
      end
      if (RSVD_LSB >= DATA_W) begin : g_bad_rsvd
         $error("reserved field must lie inside the word");
      end
   endgenerate

   csr_sel_e          wsel;
   logic [DATA_W-1:0] ctrl_q;
   logic [NFLAGS-1:0] flags_q;
   rnd_mode_e         rnd;
   logic [DATA_W-1:0] stat_word;

   assign wsel = csr_sel_e'(wr_sel);

   fpcsr_ctrl_reg #(
      .DATA_W(DATA_W), .KEEP_LO_W(KEEP_LO_W),
      .RSVD_LSB(RSVD_LSB), .COMPAT_CTRL(COMPAT_CTRL)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && wsel == CSR_CTRL),
      .wdata(wr_data),
      .ctrl_q(ctrl_q),
      .round_mode(rnd)
   );

   fpcsr_flag_reg #(.NFLAGS(NFLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .sw_we(wr_en && wsel == CSR_STAT),
      .sw_flags(wr_data[FLAG_MSB:FLAG_LSB]),
      .hw_flags(dp_flags),
      .flags_q(flags_q)
   );

   fpcsr_rsvd_chk #(
      .DATA_W(DATA_W), .RSVD_LSB(RSVD_LSB), .COMPAT_CTRL(COMPAT_CTRL)
   ) u_rsvd (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_sel(wsel), .wdata(wr_data),
      .err_q(rsvd_err)
   );

   always_comb begin
      stat_word = '0;
      stat_word[FLAG_MSB:FLAG_LSB] = flags_q;
   end

   assign rd_data    = (csr_sel_e'(rd_sel) == CSR_STAT) ? stat_word : ctrl_q;
   assign round_mode = rnd;
endmodule

// File: rtl/fpcsr_sva.sv
module fpcsr_sva #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned NFLAGS      = 5,
   parameter int unsigned FLAG_LSB    = 7,
   parameter int unsigned KEEP_LO_W   = 7,
   parameter int unsigned RSVD_LSB    = 12,
   parameter bit          COMPAT_CTRL = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_sel,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        round_mode,
   input logic              rsvd_err,
   input logic [NFLAGS-1:0] flags_q
);
   localparam int unsigned FLAG_MSB = FLAG_LSB + NFLAGS - 1;

   logic wr_ctrl, wr_stat, rsvd_hit, err_expected;
   assign wr_ctrl  = wr_en && !wr_sel;
   assign wr_stat  = wr_en && wr_sel;
   assign rsvd_hit = |wr_data[DATA_W-1:RSVD_LSB];
   assign err_expected = wr_en && rsvd_hit && !(COMPAT_CTRL && !wr_sel);

   p_round_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> round_mode == $past(wr_data[1:0]));

   p_round_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(round_mode));

   p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_sel && !COMPAT_CTRL) |-> rd_data[DATA_W-1:KEEP_LO_W] == '0);

   p_stat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel |-> (rd_data[FLAG_LSB-1:0] == '0 && rd_data[DATA_W-1:FLAG_MSB+1] == '0));

   p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_expected |=> rsvd_err);

   p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !err_expected |=> !rsvd_err);

   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> (flags_q & $past(flags_q)) == $past(flags_q));

   p_sw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> flags_q == $past(wr_data[FLAG_MSB:FLAG_LSB]));
endmodule

bind fpcsr_top fpcsr_sva #(
   .DATA_W(DATA_W), .NFLAGS(NFLAGS), .FLAG_LSB(FLAG_LSB),
   .KEEP_LO_W(KEEP_LO_W), .RSVD_LSB(RSVD_LSB), .COMPAT_CTRL(COMPAT_CTRL)
) u_sva (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
   .round_mode(round_mode), .rsvd_err(rsvd_err), .flags_q(flags_q)
);

// File: tb/fpcsr_top_tb_top.sv
module fpcsr_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [4:0]  dp_flags = '0;
   logic [31:0] rd_data, rd_data_c;
   logic [1:0]  round_mode, round_mode_c;
   logic        rsvd_err, rsvd_err_c;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Reference state
   logic [31:0] m_ctrl, m_ctrl_c;
   logic [4:0]  m_flags;
   logic        m_err, m_err_c;

   always #5 clk = ~clk;

   fpcsr_top #(.COMPAT_CTRL(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .dp_flags(dp_flags),
      .round_mode(round_mode), .rsvd_err(rsvd_err));

   fpcsr_top #(.COMPAT_CTRL(1'b1)) dut_compat_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data_c), .dp_flags(dp_flags),
      .round_mode(round_mode_c), .rsvd_err(rsvd_err_c));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] model_read(input logic sel, input logic [31:0] c);
      return sel ? ({27'd0, m_flags} << 7) : c;
   endfunction

   task automatic compare_all();
      chk("R1 round_mode", {30'd0, round_mode}, {30'd0, m_ctrl[1:0]});
      chk("R5 rsvd_err", {31'd0, rsvd_err}, {31'd0, m_err});
      chk(rd_sel ? "R4 status read" : "R2 control read", rd_data, model_read(rd_sel, m_ctrl));
      chk("R6 compat round_mode", {30'd0, round_mode_c}, {30'd0, m_ctrl_c[1:0]});
      chk("R6 compat rsvd_err", {31'd0, rsvd_err_c}, {31'd0, m_err_c});
      chk("R6 compat read", rd_data_c, model_read(rd_sel, m_ctrl_c));
   endtask

   // One clock: model follows the edge, compare at the falling edge.
   task automatic cyc();
      @(posedge clk);
      if (!rst_n) begin
         m_ctrl = '0; m_ctrl_c = '0; m_flags = '0; m_err = 0; m_err_c = 0;
      end else begin
         m_err   = wr_en && (wr_data[31:12] != 0);
         m_err_c = wr_en && wr_sel && (wr_data[31:12] != 0);
         if (wr_en && !wr_sel) begin
            m_ctrl   = wr_data & 32'h0000_007F;
            m_ctrl_c = wr_data & 32'hFFFF_F07F;
         end
         if (wr_en && wr_sel) m_flags = wr_data[11:7];
         else                 m_flags = m_flags | dp_flags;
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic drive(input logic en, input logic sel, input logic [31:0] d,
                        input logic rs, input logic [4:0] f);
      wr_en = en; wr_sel = sel; wr_data = d; rd_sel = rs; dp_flags = f;
      cyc();
   endtask

   initial begin
      #(10 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) begin
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      m_ctrl = '0; m_ctrl_c = '0; m_flags = '0; m_err = 0; m_err_c = 0;
      repeat (3) cyc();
      rst_n = 1'b1;
      // R9: reset state
      drive(0, 0, 0, 1, 0);
      chk("R9 flags after reset", rd_data, 32'd0);
      chk("R9 round after reset", {30'd0, round_mode}, 32'd0);
      // R1: each rounding code
      for (int k = 0; k < 4; k++) begin
         drive(1, 0, 32'(k), 0, 0);
         chk("R1 round code", {30'd0, round_mode}, 32'(k));
      end
      // R2 / R5: reserved bits masked, pulse one cycle
      drive(1, 0, 32'hFFFF_FFFF, 0, 0);
      chk("R2 control masked", rd_data, 32'h0000_007F);
      chk("R5 pulse", {31'd0, rsvd_err}, 32'd1);
      chk("R6 compat keeps upper", rd_data_c, 32'hFFFF_F07F);
      chk("R6 compat no pulse", {31'd0, rsvd_err_c}, 32'd0);
      drive(0, 0, 0, 0, 0);
      chk("R5 pulse ends", {31'd0, rsvd_err}, 32'd0);
      // R3 / R4: status write, flag positions
      drive(1, 1, 32'hFFFF_FFFF, 1, 0);
      chk("R3 status masked", rd_data, 32'h0000_0F80);
      chk("R5 status pulse compat", {31'd0, rsvd_err_c}, 32'd1);
      drive(1, 1, 32'h0000_0080, 1, 0);
      chk("R3 inexact at bit 7", rd_data, 32'h0000_0080);
      // R7: sticky accumulation
      drive(0, 0, 0, 1, 5'b10000);
      chk("R7 invalid raised", rd_data, 32'h0000_0880);
      drive(0, 0, 0, 1, 5'b00010);
      chk("R7 sticky merge", rd_data, 32'h0000_0980);
      // R8: same-cycle collision, write wins
      drive(1, 1, 32'h0000_0200, 1, 5'b11111);
      chk("R8 write wins", rd_data, 32'h0000_0200);
      // R5: back-to-back reserved writes
      drive(1, 0, 32'h0001_0003, 0, 0);
      drive(1, 0, 32'h8000_0001, 0, 0);
      chk("R5 back-to-back pulse", {31'd0, rsvd_err}, 32'd1);
      drive(0, 0, 0, 0, 0);
      // Random phase
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] d;
         d = $urandom;
         if ($urandom_range(0, 3) != 0) d[31:12] = '0;
         drive($urandom_range(0, 2) == 0, 1'($urandom), d, 1'($urandom),
               ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'd0);
      end
      // R9: reset mid-run
      rst_n = 1'b0;
      drive(0, 0, 0, 1, 0);
      rst_n = 1'b1;
      drive(0, 0, 0, 1, 0);
      chk("R9 flags cleared by reset", rd_data, 32'd0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule